// File: doc/BRIEF.md
# Instruction Decoder with Fault Classification

This block turns one 32-bit instruction word into the fields an execution stage needs: a numeric operation code, destination and source register numbers, an operand that is either an immediate value or a register number, and, for conditional skips, a condition code and a skip distance. It is purely combinational. The instruction word goes in, and the decoded fields come out in the same cycle.

Besides decoding, the block sorts every word that cannot execute into one of two fault kinds. An *unsupported* fault means the encoding is valid but this build leaves out the hardware for it. This covers the multiply/divide group when the `HAS_MULDIV` parameter is 0. An *illegal* fault means no operation is defined for that class and sub-opcode pair. For an illegal word the raw instruction word is presented as the fault argument, so a trap handler can inspect it. For an unsupported word the register and operand fields are still passed on, so a handler can emulate the operation in software. The return opcode serves both plain return and return-from-interrupt, and a flag bit selects between them.

There are no states and no transitions. The block is a single combinational path: field split, then the per-class group decoders, then fault classification.

Top module: `idec_core`

## Requirements
- R1: The word layout is [31:30] class, [29] flag, [28:25] sub-opcode, [24:21] destination register, [20:17] source register, [16] immediate select, [15:0] operand. `dst_reg`, `src_reg`, `opnd_is_imm` and `opnd_value` always carry these fields, including when a fault is raised.
- R2: Class 0 always decodes to copy (op code 1) with no fault.
- R3: In class 1, sub-opcodes 1 to 8 decode to op code sub+1 (add 2, subtract 3, or 4, and 5, xor 6, shift left 7, logical shift right 8, arithmetic shift right 9).
- R4: In class 1, sub-opcodes 9 to 14 are the multiply/divide group. With `HAS_MULDIV`=1 they decode to op code sub+1 (signed mul low 10, signed mul high 11, unsigned mul low 12, unsigned mul high 13, divide 14, modulo 15). With `HAS_MULDIV`=0 they give op code 0 and fault kind 5.
- R5: In class 2, sub-opcodes 0 to 3 give op code 16+sub (store, load, push, pop). Sub-opcode 9 gives software interrupt (22), 11 gives interrupt disable (23), 12 gives interrupt enable (24), 13 gives read stack pointer (25) and 14 gives write stack pointer (26). The flag bit has no effect on any of these.
- R6: In class 2, sub-opcode 8 gives return (20) when the flag bit is 0 and return-from-interrupt (21) when it is 1.
- R7: Class 3 decodes to skip (27) and never faults. `skip_cond` equals the sub-opcode and `skip_dist` equals the destination-register field. Both are 0 for every other class.
- R8: Class 1 sub-opcodes 0 and 15, and class 2 sub-opcodes 4 to 7, 10 and 15, give op code 0 and fault kind 6.
- R9: `fault_valid` is 1 exactly when `fault_kind` is non-zero. The kind is 0 for a word that decodes cleanly, and only the values 0, 5 and 6 occur.
- R10: `fault_arg` equals the whole instruction word for an illegal fault and is 0 otherwise, including for an unsupported fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| op_code | output | 5 | Decoded operation code, 0 on any fault |
| dst_reg | output | 4 | Destination register field |
| src_reg | output | 4 | Source register field |
| opnd_is_imm | output | 1 | Operand is an immediate (1) or a register number (0) |
| opnd_value | output | 16 | Operand field |
| skip_cond | output | 4 | Condition code for a skip, else 0 |
| skip_dist | output | 4 | Skip distance for a skip, else 0 |
| fault_valid | output | 1 | Word cannot execute |
| fault_kind | output | 3 | 0 clean, 5 unsupported, 6 illegal |
| fault_arg | output | 32 | Raw word on an illegal fault, else 0 |

## Verification
The bench sweeps every class, sub-opcode and flag combination on two instances, one with the multiply/divide group present and one without. A design that keyed the unsupported trap to the wrong sub-opcode range, or that ignored the parameter, would show a wrong op code or kind on exactly one of the two instances. It also targets the return pair, where a design that ignored bit 29 would report plain return for return-from-interrupt. It covers the holes in class 2 (4 to 7, 10, 15), where a decoder that fell through to a default operation would miss the illegal fault or drop the raw word from the fault argument. Random words with random register and operand bits catch fields that are zeroed or shifted on the fault paths.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int WORD_W  = 32;
    localparam int CLS_W   = 2;
    localparam int SUB_W   = 4;
    localparam int REG_W   = 4;
    localparam int OPND_W  = 16;
    localparam int OP_W    = 5;
    localparam int KIND_W  = 3;

    // Bit positions, derived top-down from the field widths
    localparam int CLS_LSB  = WORD_W - CLS_W;
    localparam int FLAG_POS = CLS_LSB - 1;
    localparam int SUB_LSB  = FLAG_POS - SUB_W;
    localparam int RD_LSB   = SUB_LSB - REG_W;
    localparam int RX_LSB   = RD_LSB - REG_W;
    localparam int IMM_POS  = RX_LSB - 1;

    typedef enum logic [CLS_W-1:0] {
        CLS_MOVE   = 2'd0,
        CLS_ALU    = 2'd1,
        CLS_MEMCTL = 2'd2,
        CLS_SKIP   = 2'd3
    } cls_e;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 5'd0,
        OP_COPY  = 5'd1,
        OP_ADD   = 5'd2,
        OP_SUB   = 5'd3,
        OP_OR    = 5'd4,
        OP_AND   = 5'd5,
        OP_XOR   = 5'd6,
        OP_LSL   = 5'd7,
        OP_LSR   = 5'd8,
        OP_ASR   = 5'd9,
        OP_SMULL = 5'd10,
        OP_SMULH = 5'd11,
        OP_UMULL = 5'd12,
        OP_UMULH = 5'd13,
        OP_DIV   = 5'd14,
        OP_MOD   = 5'd15,
        OP_STORE = 5'd16,
        OP_LOAD  = 5'd17,
        OP_PUSH  = 5'd18,
        OP_POP   = 5'd19,
        OP_RET   = 5'd20,
        OP_RETI  = 5'd21,
        OP_SWI   = 5'd22,
        OP_DINT  = 5'd23,
        OP_EINT  = 5'd24,
        OP_GETSP = 5'd25,
        OP_SETSP = 5'd26,
        OP_SKIP  = 5'd27
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_UNSUP   = 2'd1,
        ST_ILLEGAL = 2'd2
    } dec_st_e;

    localparam logic [KIND_W-1:0] KIND_NONE    = 3'd0;
    localparam logic [KIND_W-1:0] KIND_UNSUP   = 3'd5;
    localparam logic [KIND_W-1:0] KIND_ILLEGAL = 3'd6;

    typedef struct packed {
        cls_e              cls;
        logic              flag;
        logic [SUB_W-1:0]  sub;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rx;
        logic              imm;
        logic [OPND_W-1:0] opnd;
    } fields_t;

endpackage

// File: rtl/idec_field_split.sv
module idec_field_split
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           fld
);

    always_comb begin
        fld.cls  = cls_e'(word[WORD_W-1 -: CLS_W]);
        fld.flag = word[FLAG_POS];
        fld.sub  = word[SUB_LSB +: SUB_W];
        fld.rd   = word[RD_LSB +: REG_W];
        fld.rx   = word[RX_LSB +: REG_W];
        fld.imm  = word[IMM_POS];
        fld.opnd = word[OPND_W-1:0];
    end

endmodule

// File: rtl/idec_alu_group.sv
module idec_alu_group
    import idec_pkg::*;
#(
    parameter bit HAS_MULDIV = 1'b1
) (
    input  logic [SUB_W-1:0] sub,
    output op_e              op,
    output dec_st_e          st
);

    localparam logic [SUB_W-1:0] BASIC_LO = 4'd1;
    localparam logic [SUB_W-1:0] BASIC_HI = 4'd8;
    localparam logic [SUB_W-1:0] MD_LO    = 4'd9;
    localparam logic [SUB_W-1:0] MD_HI    = 4'd14;

    op_e     md_op;
    dec_st_e md_st;
    op_e     direct_op;

    assign direct_op = op_e'(OP_W'(sub) + OP_W'(1));

    generate
        if (HAS_MULDIV) begin : g_muldiv
            assign md_op = direct_op;
            assign md_st = ST_OK;
        end else begin : g_no_muldiv
            assign md_op = OP_NONE;
            assign md_st = ST_UNSUP;
        end
    endgenerate

    always_comb begin
        if (sub >= BASIC_LO && sub <= BASIC_HI) begin
            op = direct_op;
            st = ST_OK;
        end else if (sub >= MD_LO && sub <= MD_HI) begin
            op = md_op;
            st = md_st;
        end else begin
            op = OP_NONE;
            st = ST_ILLEGAL;
        end
    end

endmodule

// File: rtl/idec_ctrl_group.sv
module idec_ctrl_group
    import idec_pkg::*;
(
    input  logic [SUB_W-1:0] sub,
    input  logic             flag,
    output op_e              op,
    output dec_st_e          st
);

    always_comb begin
        op = OP_NONE;
        st = ST_OK;
        unique case (sub)
            4'd0:    op = OP_STORE;
            4'd1:    op = OP_LOAD;
            4'd2:    op = OP_PUSH;
            4'd3:    op = OP_POP;
            4'd8:    op = flag ? OP_RETI : OP_RET;
            4'd9:    op = OP_SWI;
            4'd11:   op = OP_DINT;
            4'd12:   op = OP_EINT;
            4'd13:   op = OP_GETSP;
            4'd14:   op = OP_SETSP;
            default: st = ST_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/idec_core.sv
module idec_core
    import idec_pkg::*;
#(
    parameter bit HAS_MULDIV = 1'b1
) (
    input  logic [WORD_W-1:0] instr_word,
    output logic [OP_W-1:0]   op_code,
    output logic [REG_W-1:0]  dst_reg,
    output logic [REG_W-1:0]  src_reg,
    output logic              opnd_is_imm,
    output logic [OPND_W-1:0] opnd_value,
    output logic [SUB_W-1:0]  skip_cond,
    output logic [REG_W-1:0]  skip_dist,
    output logic              fault_valid,
    output logic [KIND_W-1:0] fault_kind,
    output logic [WORD_W-1:0] fault_arg
);

    fields_t fld;
    op_e     alu_op;
    dec_st_e alu_st;
    op_e     ctl_op;
    dec_st_e ctl_st;
    op_e     sel_op;
    dec_st_e sel_st;

    idec_field_split u_split (
        .word (instr_word),
        .fld  (fld)
    );

    idec_alu_group #(.HAS_MULDIV(HAS_MULDIV)) u_alu (
        .sub (fld.sub),
        .op  (alu_op),
        .st  (alu_st)
    );

    idec_ctrl_group u_ctl (
        .sub  (fld.sub),
        .flag (fld.flag),
        .op   (ctl_op),
        .st   (ctl_st)
    );

    // Class select
    always_comb begin
        unique case (fld.cls)
            CLS_MOVE: begin
                sel_op = OP_COPY;
                sel_st = ST_OK;
            end
            CLS_ALU: begin
                sel_op = alu_op;
                sel_st = alu_st;
            end
            CLS_MEMCTL: begin
                sel_op = ctl_op;
                sel_st = ctl_st;
            end
            default: begin
                sel_op = OP_SKIP;
                sel_st = ST_OK;
            end
        endcase
    end

    // Fault classification and outputs
    always_comb begin
        fault_arg = '0;
        unique case (sel_st)
            ST_OK:      fault_kind = KIND_NONE;
            ST_UNSUP:   fault_kind = KIND_UNSUP;
            default: begin
                fault_kind = KIND_ILLEGAL;
                fault_arg  = instr_word;
            end
        endcase
        fault_valid = (sel_st != ST_OK);
        op_code     = (sel_st == ST_OK) ? sel_op : OP_NONE;
        dst_reg     = fld.rd;
        src_reg     = fld.rx;
        opnd_is_imm = fld.imm;
        opnd_value  = fld.opnd;
        skip_cond   = (fld.cls == CLS_SKIP) ? fld.sub : '0;
        skip_dist   = (fld.cls == CLS_SKIP) ? fld.rd  : '0;
    end

endmodule

// File: rtl/idec_core_chk.sv
module idec_core_chk
    import idec_pkg::*;
#(
    parameter bit HAS_MULDIV = 1'b1
) (
    input logic [WORD_W-1:0] instr_word,
    input logic [OP_W-1:0]   op_code,
    input logic [SUB_W-1:0]  skip_cond,
    input logic              fault_valid,
    input logic [KIND_W-1:0] fault_kind,
    input logic [WORD_W-1:0] fault_arg
);

    logic [CLS_W-1:0] w_cls;
    logic [SUB_W-1:0] w_sub;
    logic             w_flag;

    assign w_cls  = instr_word[WORD_W-1 -: CLS_W];
    assign w_sub  = instr_word[SUB_LSB +: SUB_W];
    assign w_flag = instr_word[FLAG_POS];

    always_comb begin
        if (!$isunknown(instr_word)) begin
            p_valid_kind_r9: assert (fault_valid == (fault_kind != 3'd0))
                else $error("valid/kind mismatch");
            p_kind_set_r9: assert (fault_kind == 3'd0 || fault_kind == 3'd5 || fault_kind == 3'd6)
                else $error("unexpected fault kind");
            p_fault_op_r8: assert (!fault_valid || op_code == 5'd0)
                else $error("op code present on fault");
            p_arg_r10: assert ((fault_kind == 3'd6) ? (fault_arg == instr_word) : (fault_arg == '0))
                else $error("fault argument wrong");
            p_skip_r7: assert (w_cls != 2'd3 || (op_code == 5'd27 && !fault_valid && skip_cond == w_sub))
                else $error("skip decode wrong");
            p_ret_r6: assert (!(w_cls == 2'd2 && w_sub == 4'd8) || op_code == (w_flag ? 5'd21 : 5'd20))
                else $error("return pair wrong");
            p_muldiv_r4: assert (!(w_cls == 2'd1 && w_sub >= 4'd9 && w_sub <= 4'd14)
                                 || (HAS_MULDIV ? (op_code == 5'(w_sub) + 5'd1) : (fault_kind == 3'd5)))
                else $error("multiply/divide group wrong");
        end
    end

endmodule

bind idec_core idec_core_chk #(.HAS_MULDIV(HAS_MULDIV)) u_chk (
    .instr_word  (instr_word),
    .op_code     (op_code),
    .skip_cond   (skip_cond),
    .fault_valid (fault_valid),
    .fault_kind  (fault_kind),
    .fault_arg   (fault_arg)
);

// File: tb/idec_core_test.sv
module idec_core_test;

    localparam time HALF = 2.5ns;
    localparam int  WATCHDOG_CYCLES = 150000;
    localparam int  N_RANDOM = 3000;

    logic clk = 1'b0;
    always #(HALF) clk = ~clk;

    logic [31:0] word = 32'h0;

    logic [4:0]  a_op, b_op;
    logic [3:0]  a_rd, b_rd, a_rx, b_rx, a_cond, b_cond, a_dist, b_dist;
    logic        a_imm, b_imm, a_fv, b_fv;
    logic [15:0] a_opnd, b_opnd;
    logic [2:0]  a_kind, b_kind;
    logic [31:0] a_arg, b_arg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    idec_core #(.HAS_MULDIV(1'b1)) uut (
        .instr_word (word), .op_code (a_op), .dst_reg (a_rd), .src_reg (a_rx),
        .opnd_is_imm (a_imm), .opnd_value (a_opnd), .skip_cond (a_cond),
        .skip_dist (a_dist), .fault_valid (a_fv), .fault_kind (a_kind),
        .fault_arg (a_arg)
    );

    idec_core #(.HAS_MULDIV(1'b0)) uut_nomd (
        .instr_word (word), .op_code (b_op), .dst_reg (b_rd), .src_reg (b_rx),
        .opnd_is_imm (b_imm), .opnd_value (b_opnd), .skip_cond (b_cond),
        .skip_dist (b_dist), .fault_valid (b_fv), .fault_kind (b_kind),
        .fault_arg (b_arg)
    );

    // Reference model written from the requirements
    function automatic logic [4:0] ref_op(logic [31:0] w, bit md);
        logic [1:0] c = w[31:30];
        logic [3:0] s = w[28:25];
        case (c)
            2'd0: return 5'd1;
            2'd1: begin
                if (s >= 1 && s <= 8)  return 5'(s) + 5'd1;
                if (s >= 9 && s <= 14) return md ? 5'(s) + 5'd1 : 5'd0;
                return 5'd0;
            end
            2'd2: begin
                if (s <= 3) return 5'd16 + 5'(s);
                case (s)
                    4'd8:  return w[29] ? 5'd21 : 5'd20;
                    4'd9:  return 5'd22;
                    4'd11: return 5'd23;
                    4'd12: return 5'd24;
                    4'd13: return 5'd25;
                    4'd14: return 5'd26;
                    default: return 5'd0;
                endcase
            end
            default: return 5'd27;
        endcase
    endfunction

    function automatic logic [2:0] ref_kind(logic [31:0] w, bit md);
        if (ref_op(w, md) != 5'd0) return 3'd0;
        if (w[31:30] == 2'd1 && w[28:25] >= 9 && w[28:25] <= 14) return 3'd5;
        return 3'd6;
    endfunction

    function automatic string op_tag(logic [31:0] w, bit md);
        logic [3:0] s = w[28:25];
        if (ref_kind(w, md) == 3'd6) return "R8";
        case (w[31:30])
            2'd0: return "R2";
            2'd1: return (s >= 9 && s <= 14) ? "R4" : "R3";
            2'd2: return (s == 8) ? "R6" : "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp, bit md);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s word=%h muldiv=%0d actual=%h expected=%h",
                     tag, what, word, md, act, exp);
        end
    endtask

    task automatic check_inst(bit md, logic [4:0] op, logic [3:0] rd, logic [3:0] rx,
                              logic imm, logic [15:0] opnd, logic [3:0] cnd,
                              logic [3:0] dst, logic fv, logic [2:0] kind,
                              logic [31:0] arg);
        logic [2:0] ek = ref_kind(word, md);
        bit skip = (word[31:30] == 2'd3);
        cmp(op_tag(word, md), "op", 32'(op), 32'(ref_op(word, md)), md);
        cmp((ek == 3'd5) ? "R4" : "R8", "kind", 32'(kind), 32'(ek), md);
        cmp("R9", "valid", 32'(fv), 32'(ek != 3'd0), md);
        cmp("R10", "arg", arg, (ek == 3'd6) ? word : 32'h0, md);
        cmp("R1", "fields", {14'h0, rd, rx, imm, opnd}, {14'h0, word[24:0]}, md);
        cmp("R7", "skip", {24'h0, cnd, dst},
            skip ? {24'h0, word[28:25], word[24:21]} : 32'h0, md);
    endtask

    task automatic apply(logic [31:0] w);
        @(posedge clk);
        word = w;
        @(negedge clk);
        check_inst(1'b1, a_op, a_rd, a_rx, a_imm, a_opnd, a_cond, a_dist, a_fv, a_kind, a_arg);
        check_inst(1'b0, b_op, b_rd, b_rx, b_imm, b_opnd, b_cond, b_dist, b_fv, b_kind, b_arg);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Idle word: all-zero decodes as copy with no fault (R2)
        apply(32'h0000_0000);
        // Directed corners: return pair (R6), mul/div edges (R4), holes (R8), skip (R7)
        apply(32'hB000_0000);
        apply(32'h9000_0000);
        apply(32'hB5FF_FFFF);
        apply(32'h5200_0000);
        apply(32'h5DFF_FFFF);
        apply(32'h4000_0000);
        apply(32'h5E12_3456);
        apply(32'hAFFF_FFFF);
        apply(32'hFFFF_FFFF);
        // Full sweep of class, flag, sub-opcode with random low bits
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 2; f++) begin
                for (int s = 0; s < 16; s++) begin
                    apply({2'(c), 1'(f), 4'(s), 25'($urandom)});
                end
            end
        end
        // Random words
        for (int i = 0; i < N_RANDOM; i++) begin
            apply($urandom);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule